// File: doc/BRIEF.md
# Pipelined Complex Multiplier with Optional Conjugation

This block forms the exact product of two signed complex operands, a = a_re + j·a_im and b = b_re + j·b_im. A build-time parameter selects whether it computes a·b or a·conj(b). The arithmetic is split across four register groups: operand capture, partial products, combination of the products, and result. Each group has its own depth parameter, and any depth may be zero. The end-to-end latency is the sum of the four depths.

A single valid bit travels beside the data through a delay of the same total length. The arithmetic never looks at this bit. It only marks which outputs belong to meaningful inputs. A synchronous reset clears every register. A clock enable freezes the whole pipeline, including the valid delay, for as long as it is low.

Each result part is 2·OP_W+1 bits wide. This is enough for the sum or difference of two full-width products, so no operand combination overflows. That includes the most negative value in all four operands.

Top module: `cplx_conj_mult`

## Requirements
- R1: With MODE = CM_PLAIN, prod_re = a_re·b_re − a_im·b_im and prod_im = a_re·b_im + a_im·b_re.
- R2: With MODE = CM_CONJ_B, prod_re = a_re·b_re + a_im·b_im and prod_im = a_im·b_re − a_re·b_im.
- R3: A result appears exactly N_IN+N_PROD+N_ADD+N_OUT enabled clock edges after its operands were sampled. Any of the four depths may be zero.
- R4: out_vld equals in_vld delayed by the same latency as the data. The value of in_vld has no effect on prod_re or prod_im.
- R5: Results are exact, as signed two's complement values of 2·OP_W+1 bits, for every operand combination. This covers the extremes: all operands at the positive maximum, mixed maximum and minimum, all operands at the minimum, and every combination of small values from −2 to 2.
- R6: While rst is high at a clock edge, every pipeline register and the valid delay load zero. After that edge, with a nonzero latency, prod_re, prod_im and out_vld read 0.
- R7: While ce is low, no register changes. The outputs and out_vld hold their values.
- R8: The operand width OP_W is a parameter, 18 by default, and is shared by both operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Clock enable for all registers |
| a_re | input | OP_W | Real part of operand a, signed |
| a_im | input | OP_W | Imaginary part of operand a, signed |
| b_re | input | OP_W | Real part of operand b, signed |
| b_im | input | OP_W | Imaginary part of operand b, signed |
| in_vld | input | 1 | Valid marker accompanying the operands |
| prod_re | output | 2·OP_W+1 | Real part of the result, signed |
| prod_im | output | 2·OP_W+1 | Imaginary part of the result, signed |
| out_vld | output | 1 | in_vld delayed by the pipeline latency |

## Verification
The bench builds two copies at the default operand width of 18 bits, so the sign and width corners are the real ones. The first copy computes the plain product with depths 1/0/1/1. The second copy computes with the conjugate of b, using depths 0/2/1/0. That puts zero-depth groups at both the input and output ends and a two-deep product group in between. With both copies in place, a single run covers both arithmetic modes and both the presence and absence of operand and result registers, at the same total latency of three. Random clock-enable gaps and a reset in the middle of the run test that the data and the valid bit stay in lockstep.

// File: rtl/cmul_pkg.sv
package cmul_pkg;

    typedef enum logic {
        CM_PLAIN  = 1'b0,
        CM_CONJ_B = 1'b1
    } cm_mode_e;

    function automatic int cm_latency(input int n_in, input int n_prod,
                                      input int n_add, input int n_out);
        return n_in + n_prod + n_add + n_out;
    endfunction

endpackage

// File: rtl/cmul_pipe.sv
module cmul_pipe #(
    parameter int W = 8,
    parameter int N = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ce,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    generate
        if (N == 0) begin : g_wire
            logic unused_ctl;
            assign unused_ctl = ^{clk, rst, ce};
            assign q = d;
        end else begin : g_regs
            logic [W-1:0] stg_d [N];
            logic [W-1:0] stg_q [N];

            always_comb begin
                stg_d[0] = d;
                for (int i = 1; i < N; i++) begin
                    stg_d[i] = stg_q[i-1];
                end
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < N; i++) begin
                        stg_q[i] <= '0;
                    end
                end else if (ce) begin
                    stg_q <= stg_d;
                end
            end

            assign q = stg_q[N-1];

            // R7: a disabled clock enable freezes the stage output
            a_r7_stage_hold: assert property (@(posedge clk) disable iff (rst)
                !ce |=> $stable(q));

            // R6: the edge after reset shows a cleared stage
            a_r6_stage_clear: assert property (@(posedge clk) disable iff (rst)
                $past(rst) |-> (q == '0));
        end
    endgenerate

endmodule

// File: rtl/cmul_prod.sv
module cmul_prod #(
    parameter int OP_W = 18,
    localparam int PW  = 2 * OP_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic signed [OP_W-1:0] a_re,
    input  logic signed [OP_W-1:0] a_im,
    input  logic signed [OP_W-1:0] b_re,
    input  logic signed [OP_W-1:0] b_im,
    output logic signed [PW-1:0]   p_rr,
    output logic signed [PW-1:0]   p_ii,
    output logic signed [PW-1:0]   p_ri,
    output logic signed [PW-1:0]   p_ir
);

    always_comb begin
        p_rr = PW'(a_re) * PW'(b_re);
        p_ii = PW'(a_im) * PW'(b_im);
        p_ri = PW'(a_re) * PW'(b_im);
        p_ir = PW'(a_im) * PW'(b_re);
    end

    // R1: a zero real part of a zeroes both products it feeds
    a_r1_zero_factor: assert property (@(posedge clk) disable iff (rst)
        (a_re == '0) |-> (p_rr == '0 && p_ri == '0));

endmodule

// File: rtl/cmul_comb.sv
module cmul_comb
    import cmul_pkg::*;
#(
    parameter int       OP_W = 18,
    parameter cm_mode_e MODE = CM_PLAIN,
    localparam int      PW   = 2 * OP_W,
    localparam int      RW   = 2 * OP_W + 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic signed [PW-1:0] p_rr,
    input  logic signed [PW-1:0] p_ii,
    input  logic signed [PW-1:0] p_ri,
    input  logic signed [PW-1:0] p_ir,
    output logic signed [RW-1:0] res_re,
    output logic signed [RW-1:0] res_im
);

    logic signed [RW-1:0] e_rr, e_ii, e_ri, e_ir;

    always_comb begin
        e_rr = {p_rr[PW-1], p_rr};
        e_ii = {p_ii[PW-1], p_ii};
        e_ri = {p_ri[PW-1], p_ri};
        e_ir = {p_ir[PW-1], p_ir};
    end

    generate
        if (MODE == CM_CONJ_B) begin : g_conj
            always_comb begin
                res_re = e_rr + e_ii;
                res_im = e_ir - e_ri;
            end
            // R2: equal cross products cancel in the imaginary part
            a_r2_cross_cancel: assert property (@(posedge clk) disable iff (rst)
                (p_ri == p_ir) |-> (res_im == '0));
        end else begin : g_plain
            always_comb begin
                res_re = e_rr - e_ii;
                res_im = e_ri + e_ir;
            end
            // R1: equal direct products cancel in the real part
            a_r1_direct_cancel: assert property (@(posedge clk) disable iff (rst)
                (p_rr == p_ii) |-> (res_re == '0));
        end
    endgenerate

endmodule

// File: rtl/cplx_conj_mult.sv
module cplx_conj_mult
    import cmul_pkg::*;
#(
    parameter int       OP_W   = 18,
    parameter cm_mode_e MODE   = CM_PLAIN,
    parameter int       N_IN   = 1,
    parameter int       N_PROD = 0,
    parameter int       N_ADD  = 1,
    parameter int       N_OUT  = 1,
    localparam int      PW     = 2 * OP_W,
    localparam int      RW     = 2 * OP_W + 1,
    localparam int      LAT    = cm_latency(N_IN, N_PROD, N_ADD, N_OUT)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ce,
    input  logic [OP_W-1:0]      a_re,
    input  logic [OP_W-1:0]      a_im,
    input  logic [OP_W-1:0]      b_re,
    input  logic [OP_W-1:0]      b_im,
    input  logic                 in_vld,
    output logic [RW-1:0]        prod_re,
    output logic [RW-1:0]        prod_im,
    output logic                 out_vld
);

    logic [4*OP_W-1:0] ops_q;
    logic [4*PW-1:0]   pp_d, pp_q;
    logic [2*RW-1:0]   sum_d, sum_q, res_q;

    logic signed [OP_W-1:0] s_are, s_aim, s_bre, s_bim;
    logic signed [PW-1:0]   p_rr, p_ii, p_ri, p_ir;
    logic signed [RW-1:0]   c_re, c_im;

    cmul_pipe #(.W(4*OP_W), .N(N_IN)) u_in_stg (
        .clk(clk), .rst(rst), .ce(ce),
        .d({a_re, a_im, b_re, b_im}), .q(ops_q)
    );

    assign {s_are, s_aim, s_bre, s_bim} = ops_q;

    cmul_prod #(.OP_W(OP_W)) u_prod (
        .clk(clk), .rst(rst),
        .a_re(s_are), .a_im(s_aim), .b_re(s_bre), .b_im(s_bim),
        .p_rr(p_rr), .p_ii(p_ii), .p_ri(p_ri), .p_ir(p_ir)
    );

    assign pp_d = {p_rr, p_ii, p_ri, p_ir};

    cmul_pipe #(.W(4*PW), .N(N_PROD)) u_prod_stg (
        .clk(clk), .rst(rst), .ce(ce), .d(pp_d), .q(pp_q)
    );

    cmul_comb #(.OP_W(OP_W), .MODE(MODE)) u_comb (
        .clk(clk), .rst(rst),
        .p_rr(pp_q[4*PW-1:3*PW]), .p_ii(pp_q[3*PW-1:2*PW]),
        .p_ri(pp_q[2*PW-1:PW]),   .p_ir(pp_q[PW-1:0]),
        .res_re(c_re), .res_im(c_im)
    );

    assign sum_d = {c_re, c_im};

    cmul_pipe #(.W(2*RW), .N(N_ADD)) u_add_stg (
        .clk(clk), .rst(rst), .ce(ce), .d(sum_d), .q(sum_q)
    );

    cmul_pipe #(.W(2*RW), .N(N_OUT)) u_out_stg (
        .clk(clk), .rst(rst), .ce(ce), .d(sum_q), .q(res_q)
    );

    assign {prod_re, prod_im} = res_q;

    cmul_pipe #(.W(1), .N(LAT)) u_vld_dly (
        .clk(clk), .rst(rst), .ce(ce), .d(in_vld), .q(out_vld)
    );

    generate
        if (LAT > 0) begin : g_chk
            // R7: the whole result side freezes while ce is low
            a_r7_hold_out: assert property (@(posedge clk) disable iff (rst)
                !ce |=> ($stable(prod_re) && $stable(prod_im) && $stable(out_vld)));

            // R6: reset leaves data and valid cleared
            a_r6_reset_out: assert property (@(posedge clk) disable iff (rst)
                $past(rst) |-> (prod_re == '0 && prod_im == '0 && !out_vld));
        end
    endgenerate

endmodule

// File: tb/tb_cplx_conj_mult.sv
`timescale 1ns/1ps
module tb_cplx_conj_mult;
    import cmul_pkg::*;

    localparam int OPW  = 18;
    localparam int RW   = 2 * OPW + 1;
    localparam int MAXV = (1 <<< (OPW - 1)) - 1;
    localparam int MINV = -(1 <<< (OPW - 1));
    localparam int LAT0 = 1 + 0 + 1 + 1;
    localparam int LAT1 = 0 + 2 + 1 + 0;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ce  = 1'b1;
    logic vld = 1'b0;
    int   x_ar = 0, x_ai = 0, x_br = 0, x_bi = 0;
    logic [OPW-1:0] d_ar, d_ai, d_br, d_bi;

    assign d_ar = x_ar[OPW-1:0];
    assign d_ai = x_ai[OPW-1:0];
    assign d_br = x_br[OPW-1:0];
    assign d_bi = x_bi[OPW-1:0];

    logic signed [RW-1:0] o_re0, o_im0, o_re1, o_im1;
    logic o_v0, o_v1;

    always #2.5 clk = ~clk;

    cplx_conj_mult dut (
        .clk(clk), .rst(rst), .ce(ce),
        .a_re(d_ar), .a_im(d_ai), .b_re(d_br), .b_im(d_bi), .in_vld(vld),
        .prod_re(o_re0), .prod_im(o_im0), .out_vld(o_v0)
    );

    cplx_conj_mult #(.MODE(CM_CONJ_B), .N_IN(0), .N_PROD(2), .N_ADD(1), .N_OUT(0)) dut_cj (
        .clk(clk), .rst(rst), .ce(ce),
        .a_re(d_ar), .a_im(d_ai), .b_re(d_br), .b_im(d_bi), .in_vld(vld),
        .prod_re(o_re1), .prod_im(o_im1), .out_vld(o_v1)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    longint h_re [2][64];
    longint h_im [2][64];
    bit     h_v  [2][64];
    int     cnt  [2];

    function automatic longint ref_re(input int ar, ai, br, bi, input bit cj);
        longint pr, pi;
        pr = longint'(ar) * longint'(br);
        pi = longint'(ai) * longint'(bi);
        return cj ? pr + pi : pr - pi;
    endfunction

    function automatic longint ref_im(input int ar, ai, br, bi, input bit cj);
        longint x1, x2;
        x1 = longint'(ar) * longint'(bi);
        x2 = longint'(ai) * longint'(br);
        return cj ? x2 - x1 : x1 + x2;
    endfunction

    function automatic int rand_op();
        int sel;
        sel = int'($urandom % 8);
        case (sel)
            0: return MAXV;
            1: return MINV;
            2: return int'($urandom % 11) - 5;
            default: return int'($urandom % (1 << OPW)) + MINV;
        endcase
    endfunction

    task automatic check(input string tag, input string what, input longint act, input longint exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic step(input string tag);
        int lat;
        longint er, ei;
        bit ev;
        @(posedge clk);
        for (int k = 0; k < 2; k++) begin
            if (rst) begin
                cnt[k] = 0;
            end else if (ce) begin
                h_re[k][cnt[k] % 64] = ref_re(x_ar, x_ai, x_br, x_bi, k == 1);
                h_im[k][cnt[k] % 64] = ref_im(x_ar, x_ai, x_br, x_bi, k == 1);
                h_v[k][cnt[k] % 64]  = vld;
                cnt[k]++;
            end
        end
        @(negedge clk);
        for (int k = 0; k < 2; k++) begin
            lat = (k == 0) ? LAT0 : LAT1;
            if (cnt[k] >= lat) begin
                er = h_re[k][(cnt[k] - lat) % 64];
                ei = h_im[k][(cnt[k] - lat) % 64];
                ev = h_v[k][(cnt[k] - lat) % 64];
            end else begin
                er = 0; ei = 0; ev = 1'b0;
            end
            if (k == 0) begin
                check(tag, "plain re", longint'(o_re0), er);
                check(tag, "plain im", longint'(o_im0), ei);
                check(tag, "plain vld", longint'(o_v0), longint'(ev));
            end else begin
                check(tag, "conj re", longint'(o_re1), er);
                check(tag, "conj im", longint'(o_im1), ei);
                check(tag, "conj vld", longint'(o_v1), longint'(ev));
            end
        end
    endtask

    task automatic put(input int ar, ai, br, bi, input bit v);
        x_ar = ar; x_ai = ai; x_br = br; x_bi = bi; vld = v;
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = int'($urandom(32'd20210917));
        cnt[0] = 0; cnt[1] = 0;
        @(negedge clk);
        // R6: reset state, outputs and valid read zero
        for (int i = 0; i < 4; i++) step("R6");
        rst = 1'b0;
        // R8: default operand width, result width 2*OPW+1 (R5)
        check("R8", "result width", longint'($bits(o_re0)), longint'(2 * 18 + 1));

        // R3: single pulse surrounded by zeros
        for (int i = 0; i < 4; i++) step("R3");
        put(3, 2, 5, -1, 1'b1); step("R3");
        put(0, 0, 0, 0, 1'b0);
        for (int i = 0; i < 6; i++) step("R3");

        // R5: extreme operands
        put(MAXV, MAXV, MAXV, MAXV, 1'b1); step("R5");
        put(MAXV, MAXV, MINV, MINV, 1'b1); step("R5");
        put(MINV, MINV, MAXV, MAXV, 1'b1); step("R5");
        put(MINV, MINV, MINV, MINV, 1'b1); step("R5");
        put(MAXV, MAXV - 1, MAXV - 2, MAXV - 3, 1'b1); step("R5");
        put(MINV, MINV + 1, MINV + 2, MINV + 3, 1'b0); step("R5");
        put(MAXV, MAXV - 1, -MAXV + 2, -MAXV + 3, 1'b1); step("R5");
        put(MINV, MINV + 1, -MAXV + 2, -MAXV + 3, 1'b1); step("R5");
        put(0, 0, 0, 0, 1'b0);
        for (int i = 0; i < 4; i++) step("R5");

        // R1, R2: exhaustive small values
        for (int i = -2; i <= 2; i++)
            for (int j = -2; j <= 2; j++)
                for (int k = -2; k <= 2; k++)
                    for (int l = -2; l <= 2; l++) begin
                        put(i, j, k, l, 1'b1);
                        step("R1/R2");
                    end

        // R4: identical operands with in_vld toggled
        for (int i = 0; i < 8; i++) begin
            put(1234, -77, -4321, 999, i[0]);
            step("R4");
        end

        // R7: clock enable held low, then resumed
        put(MAXV, -5, 7, MINV, 1'b1); step("R7");
        ce = 1'b0;
        put(11, 12, 13, 14, 1'b0);
        for (int i = 0; i < 5; i++) step("R7");
        ce = 1'b1;
        for (int i = 0; i < 5; i++) step("R7");

        // R6: reset in the middle of traffic, with ce low
        put(500, 600, -700, 800, 1'b1);
        step("R6");
        rst = 1'b1; ce = 1'b0;
        step("R6"); step("R6");
        rst = 1'b0; ce = 1'b1;
        for (int i = 0; i < 4; i++) step("R6");

        // R1, R2, R4, R7: random operands, random valid and enable gaps
        for (int i = 0; i < 3000; i++) begin
            put(rand_op(), rand_op(), rand_op(), rand_op(), 1'(($urandom % 2)));
            ce = (($urandom % 8) != 0);
            step("R1/R2/R7");
        end
        ce = 1'b1;
        put(0, 0, 0, 0, 1'b0);
        for (int i = 0; i < 6; i++) step("R3");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule